// File: doc/BRIEF.md
# Single-Accumulator Core with Index Register

This block is a small multicycle processor core. Its architectural state is one accumulator, one index register and a program counter. It runs a single-operand instruction set from a word-addressed memory with one port and a registered read. Each instruction goes through a fetch state, a decode/address state and an execute state. The one instruction that rewrites part of a memory word takes a fourth state.

Two features support compact loops. First, some instructions read or replace only the address field of a memory word, so a program can patch its own operand addresses. Second, the index register can be added to the address of memory operands. A conditional jump on that register increments it when it falls through, so a loop can count from a negative start up to zero. A halt instruction freezes the core until the next reset. Debug outputs show the accumulator, the index register and the program counter.

Top module: `acc_ix_core`

## Requirements
- R1: While reset is low, and right after it rises, PC, AC and IX read zero, halted is low and no memory write is issued.
- R2: The instruction word is opcode in bits 15:11, index flag in bit 10 and field in bits 9:0. LOAD (1) sets AC to M[x]. STORE (2) writes AC to M[x]. ADD (3) and SUB (4) add M[x] to AC or subtract it from AC, modulo 2^16. AC changes only at the end of an execute state.
- R3: SHL (5) sets AC to AC shifted left by one. SHR (6) shifts AC right by one and keeps the sign bit. Neither shift reads or writes memory.
- R4: JUMP (7) sets PC to the field. JGE (8) sets PC to the field when AC bit 15 is 0; otherwise PC advances by one. PC changes only at the end of an execute state.
- R5: LDADR (9) sets AC to the low 10 bits of M[x], zero-extended. STADR (10) replaces bits 9:0 of M[x] with AC bits 9:0 and keeps bits 15:10 of that word.
- R6: For LOAD, STORE, ADD and SUB with bit 10 set, the effective address is (field + IX) mod 1024, where IX is treated as signed. For all other opcodes bit 10 is ignored.
- R7: JZI (11) jumps to the field when IX is zero. Otherwise it increments IX by one and PC advances by one.
- R8: LDIX (12) sets IX to bits 9:0 of M[x]. STIX (13) writes IX to M[x], sign-extended to 16 bits.
- R9: INCIX (14) adds the field to IX modulo 1024, without touching AC or memory.
- R10: HALT (31) leaves PC on the halt instruction and raises halted. Halted then stays high, and PC and memory stay unchanged until reset.
- R11: Opcode 0 and every opcode not listed above does nothing except advance PC by one.
- R12: Every instruction takes three cycles, and STADR takes four. In the fetch cycle the memory address equals PC. A write never occurs in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Word address to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Registered read data from memory |
| halted | output | 1 | Core has stopped on a halt instruction |
| dbg_ac | output | 16 | Accumulator value |
| dbg_ix | output | 10 | Index register value |
| dbg_pc | output | 10 | Program counter value |

## Verification
The assertions check on every cycle the rules about when state may change. AC and PC move only out of execute. Halted is sticky and blocks all writes. Writes are never back to back. An address-field rewrite keeps the upper bits of the word it read one cycle earlier. The results of the instructions, the signed and wrapping arithmetic of indexed addresses and IX updates, and the exact cycle counts can only be shown by the bench's programs. These programs are an indexed vector-add loop, a self-patching sequence and an arithmetic/branch run, all compared against a behavioural instruction model on every clock.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam int OPC_W = 5;

   localparam logic [OPC_W-1:0] OP_NOP   = 5'd0;
   localparam logic [OPC_W-1:0] OP_LOAD  = 5'd1;
   localparam logic [OPC_W-1:0] OP_STORE = 5'd2;
   localparam logic [OPC_W-1:0] OP_ADD   = 5'd3;
   localparam logic [OPC_W-1:0] OP_SUB   = 5'd4;
   localparam logic [OPC_W-1:0] OP_SHL   = 5'd5;
   localparam logic [OPC_W-1:0] OP_SHR   = 5'd6;
   localparam logic [OPC_W-1:0] OP_JMP   = 5'd7;
   localparam logic [OPC_W-1:0] OP_JGE   = 5'd8;
   localparam logic [OPC_W-1:0] OP_LDADR = 5'd9;
   localparam logic [OPC_W-1:0] OP_STADR = 5'd10;
   localparam logic [OPC_W-1:0] OP_JZI   = 5'd11;
   localparam logic [OPC_W-1:0] OP_LDIX  = 5'd12;
   localparam logic [OPC_W-1:0] OP_STIX  = 5'd13;
   localparam logic [OPC_W-1:0] OP_INCIX = 5'd14;
   localparam logic [OPC_W-1:0] OP_HALT  = 5'd31;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_RMW    = 3'd3,
      ST_HALT   = 3'd4
   } state_e;

   typedef enum logic [2:0] {
      AC_HOLD, AC_LOAD, AC_ADD, AC_SUB, AC_SHL, AC_SHR, AC_FIELD
   } ac_op_e;

   typedef enum logic [1:0] {
      IX_HOLD, IX_LOAD, IX_ADDK, IX_JZI
   } ix_op_e;

   typedef enum logic [1:0] {
      PC_SEQ, PC_JMP, PC_JGE, PC_JZI
   } pc_op_e;

   typedef enum logic [1:0] {
      WR_NONE, WR_AC, WR_IX, WR_MERGE
   } wr_op_e;

   typedef struct packed {
      ac_op_e ac_op;
      ix_op_e ix_op;
      pc_op_e pc_op;
      wr_op_e wr_op;
      logic   idx_ok;
      logic   halt;
   } ctl_t;

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
   import acc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output ctl_t             ctl
);

   always_comb begin
      ctl.ac_op  = AC_HOLD;
      ctl.ix_op  = IX_HOLD;
      ctl.pc_op  = PC_SEQ;
      ctl.wr_op  = WR_NONE;
      ctl.idx_ok = 1'b0;
      ctl.halt   = 1'b0;
      case (opcode)
         OP_LOAD:  begin ctl.ac_op = AC_LOAD; ctl.idx_ok = 1'b1; end
         OP_STORE: begin ctl.wr_op = WR_AC;   ctl.idx_ok = 1'b1; end
         OP_ADD:   begin ctl.ac_op = AC_ADD;  ctl.idx_ok = 1'b1; end
         OP_SUB:   begin ctl.ac_op = AC_SUB;  ctl.idx_ok = 1'b1; end
         OP_SHL:   ctl.ac_op = AC_SHL;
         OP_SHR:   ctl.ac_op = AC_SHR;
         OP_JMP:   ctl.pc_op = PC_JMP;
         OP_JGE:   ctl.pc_op = PC_JGE;
         OP_LDADR: ctl.ac_op = AC_FIELD;
         OP_STADR: ctl.wr_op = WR_MERGE;
         OP_JZI:   begin ctl.pc_op = PC_JZI; ctl.ix_op = IX_JZI; end
         OP_LDIX:  ctl.ix_op = IX_LOAD;
         OP_STIX:  ctl.wr_op = WR_IX;
         OP_INCIX: ctl.ix_op = IX_ADDK;
         OP_HALT:  ctl.halt  = 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/acc_ac_alu.sv
module acc_ac_alu
   import acc_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 10,
   parameter bit SHR_ARITH = 1'b1
) (
   input  ac_op_e            op,
   input  logic [DATA_W-1:0] ac,
   input  logic [DATA_W-1:0] mem,
   output logic [DATA_W-1:0] ac_nxt
);

   localparam int PAD_W = DATA_W - ADDR_W;

   logic [DATA_W-1:0] shr_val;

   generate
      if (SHR_ARITH) begin : g_sra
         assign shr_val = {ac[DATA_W-1], ac[DATA_W-1:1]};
      end else begin : g_srl
         assign shr_val = {1'b0, ac[DATA_W-1:1]};
      end
   endgenerate

   always_comb begin
      case (op)
         AC_LOAD:  ac_nxt = mem;
         AC_ADD:   ac_nxt = ac + mem;
         AC_SUB:   ac_nxt = ac - mem;
         AC_SHL:   ac_nxt = {ac[DATA_W-2:0], 1'b0};
         AC_SHR:   ac_nxt = shr_val;
         AC_FIELD: ac_nxt = {{PAD_W{1'b0}}, mem[ADDR_W-1:0]};
         default:  ac_nxt = ac;
      endcase
   end

endmodule

// File: rtl/acc_ix_unit.sv
module acc_ix_unit
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   parameter int IX_W   = 10
) (
   input  ix_op_e            op,
   input  logic [IX_W-1:0]   ix,
   input  logic [IX_W-1:0]   mem_lo,
   input  logic [IX_W-1:0]   k,
   input  logic [ADDR_W-1:0] field,
   output logic [IX_W-1:0]   ix_nxt,
   output logic              ix_zero,
   output logic [ADDR_W-1:0] ea_idx,
   output logic [DATA_W-1:0] ix_word
);

   localparam int EXT_A = ADDR_W - IX_W;
   localparam int EXT_D = DATA_W - IX_W;

   logic [ADDR_W-1:0] ix_ext;

   generate
      if (EXT_A == 0) begin : g_same
         assign ix_ext = ix;
      end else begin : g_sext
         assign ix_ext = {{EXT_A{ix[IX_W-1]}}, ix};
      end
   endgenerate

   assign ea_idx  = field + ix_ext;
   assign ix_zero = (ix == '0);
   assign ix_word = {{EXT_D{ix[IX_W-1]}}, ix};

   always_comb begin
      case (op)
         IX_LOAD: ix_nxt = mem_lo;
         IX_ADDK: ix_nxt = ix + k;
         IX_JZI:  ix_nxt = ix_zero ? ix : ix + IX_W'(1);
         default: ix_nxt = ix;
      endcase
   end

endmodule

// File: rtl/acc_ix_core.sv
module acc_ix_core
   import acc_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 10,
   parameter int IX_W      = 10,
   parameter bit SHR_ARITH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic [DATA_W-1:0] dbg_ac,
   output logic [IX_W-1:0]   dbg_ix,
   output logic [ADDR_W-1:0] dbg_pc
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int IDX_BIT = ADDR_W;

   generate
      if (DATA_W != OPC_W + 1 + ADDR_W) begin : g_bad_word
         $error("word width must equal opcode + index flag + address field");
      end
      if (IX_W > ADDR_W || IX_W < 2) begin : g_bad_ix
         $error("index width must lie between 2 and the address field width");
      end
   endgenerate

   state_e            state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] ac_q;
   logic [IX_W-1:0]   ix_q;
   logic [OPC_W-1:0]  op_q;
   logic [ADDR_W-1:0] ea_q;
   logic [DATA_W-1:0] merge_q;

   logic [OPC_W-1:0]  dec_op;
   ctl_t              ctl;
   logic [DATA_W-1:0] ac_nxt;
   logic [IX_W-1:0]   ix_nxt;
   logic              ix_zero;
   logic [ADDR_W-1:0] ea_idx;
   logic [ADDR_W-1:0] ea_now;
   logic [DATA_W-1:0] ix_word;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] pc_nxt;

   assign dec_op = (state_q == ST_DECODE) ? mem_rdata[DATA_W-1:OPC_LSB] : op_q;

   acc_decoder u_dec (
      .opcode (dec_op),
      .ctl    (ctl)
   );

   acc_ac_alu #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .SHR_ARITH (SHR_ARITH)
   ) u_alu (
      .op     (ctl.ac_op),
      .ac     (ac_q),
      .mem    (mem_rdata),
      .ac_nxt (ac_nxt)
   );

   acc_ix_unit #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .IX_W   (IX_W)
   ) u_ix (
      .op      (ctl.ix_op),
      .ix      (ix_q),
      .mem_lo  (mem_rdata[IX_W-1:0]),
      .k       (ea_q[IX_W-1:0]),
      .field   (mem_rdata[ADDR_W-1:0]),
      .ix_nxt  (ix_nxt),
      .ix_zero (ix_zero),
      .ea_idx  (ea_idx),
      .ix_word (ix_word)
   );

   assign ea_now = (ctl.idx_ok && mem_rdata[IDX_BIT]) ? ea_idx : mem_rdata[ADDR_W-1:0];
   assign pc_inc = pc_q + ADDR_W'(1);

   always_comb begin
      case (ctl.pc_op)
         PC_JMP:  pc_nxt = ea_q;
         PC_JGE:  pc_nxt = ac_q[DATA_W-1] ? pc_inc : ea_q;
         PC_JZI:  pc_nxt = ix_zero ? ea_q : pc_inc;
         default: pc_nxt = pc_inc;
      endcase
   end

   always_comb begin
      mem_addr  = pc_q;
      mem_we    = 1'b0;
      mem_wdata = ac_q;
      case (state_q)
         ST_DECODE: mem_addr = ea_now;
         ST_EXEC: begin
            mem_addr = ea_q;
            case (ctl.wr_op)
               WR_AC: mem_we = 1'b1;
               WR_IX: begin
                  mem_we    = 1'b1;
                  mem_wdata = ix_word;
               end
               default: ;
            endcase
         end
         ST_RMW: begin
            mem_addr  = ea_q;
            mem_we    = 1'b1;
            mem_wdata = merge_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         ac_q    <= '0;
         ix_q    <= '0;
         op_q    <= '0;
         ea_q    <= '0;
         merge_q <= '0;
      end else begin
         case (state_q)
            ST_FETCH: state_q <= ST_DECODE;
            ST_DECODE: begin
               op_q    <= mem_rdata[DATA_W-1:OPC_LSB];
               ea_q    <= ea_now;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               ac_q <= ac_nxt;
               ix_q <= ix_nxt;
               if (ctl.halt) begin
                  state_q <= ST_HALT;
               end else begin
                  pc_q <= pc_nxt;
                  if (ctl.wr_op == WR_MERGE) begin
                     merge_q <= {mem_rdata[DATA_W-1:ADDR_W], ac_q[ADDR_W-1:0]};
                     state_q <= ST_RMW;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_RMW:  state_q <= ST_FETCH;
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign halted = (state_q == ST_HALT);
   assign dbg_ac = ac_q;
   assign dbg_ix = ix_q;
   assign dbg_pc = pc_q;

endmodule

// File: rtl/acc_ix_core_chk.sv
module acc_ix_core_chk
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input state_e            state,
   input logic              halted,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] ac
);

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R10

   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we); // R10

   AST_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R12

   AST_AC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_EXEC) |=> $stable(ac)); // R2

   AST_PC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_EXEC) |=> $stable(pc)); // R4

   AST_MERGE_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RMW && mem_we) |->
         (mem_wdata[DATA_W-1:ADDR_W] == $past(mem_rdata[DATA_W-1:ADDR_W]))); // R5

endmodule

bind acc_ix_core acc_ix_core_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state     (state_q),
   .halted    (halted),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .pc        (pc_q),
   .ac        (ac_q)
);

// File: tb/tb_acc_ix_core.sv
`timescale 1ns/1ps
module tb_acc_ix_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic        halted;
   logic [15:0] dbg_ac;
   logic [9:0]  dbg_ix;
   logic [9:0]  dbg_pc;

   always #10 clk = ~clk;

   acc_ix_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .dbg_ac    (dbg_ac),
      .dbg_ix    (dbg_ix),
      .dbg_pc    (dbg_pc)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] ram  [0:1023];
   logic [15:0] mref [0:1023];

   bit          clr_en = 1'b0;
   bit          ld_en = 1'b0;
   logic [9:0]  ld_a = '0;
   logic [15:0] ld_d = '0;

   // behavioural instruction model
   logic [15:0] m_ac;
   logic [9:0]  m_ix;
   logic [9:0]  m_pc;
   bit          m_halt;
   int          phase;
   logic [9:0]  pend_a;
   logic [15:0] pend_d;
   logic [15:0] w;
   logic [4:0]  op;
   logic [9:0]  fld;
   logic [9:0]  ea;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(int o, int f, bit x);
      logic [4:0] ob;
      logic [9:0] fb;
      ob = o[4:0];
      fb = f[9:0];
      return {ob, x, fb};
   endfunction

   always @(posedge clk) begin
      if (clr_en) begin
         for (int i = 0; i < 1024; i++) begin
            ram[i]  = '0;
            mref[i] = '0;
         end
      end
      if (ld_en) begin
         ram[ld_a]  = ld_d;
         mref[ld_a] = ld_d;
      end
      if (mem_we) ram[mem_addr] = mem_wdata;
      mem_rdata <= ram[mem_addr];

      if (!rst_n) begin
         m_ac = '0; m_ix = '0; m_pc = '0; m_halt = 1'b0; phase = 0;
      end else if (!m_halt) begin
         case (phase)
            0: phase = 1;
            1: phase = 2;
            3: begin
               mref[pend_a] = pend_d;
               phase = 0;
            end
            default: begin
               w   = mref[m_pc];
               op  = w[15:11];
               fld = w[9:0];
               ea  = (w[10] && op >= 5'd1 && op <= 5'd4) ? fld + m_ix : fld;
               phase = 0;
               case (op)
                  5'd1:  m_ac = mref[ea];
                  5'd2:  mref[ea] = m_ac;
                  5'd3:  m_ac = m_ac + mref[ea];
                  5'd4:  m_ac = m_ac - mref[ea];
                  5'd5:  m_ac = m_ac << 1;
                  5'd6:  m_ac = $signed(m_ac) >>> 1;
                  5'd9:  m_ac = {6'd0, mref[fld][9:0]};
                  5'd10: begin
                     pend_a = fld;
                     pend_d = {mref[fld][15:10], m_ac[9:0]};
                     phase  = 3;
                  end
                  5'd12: m_ix = mref[fld][9:0];
                  5'd13: mref[fld] = {{6{m_ix[9]}}, m_ix};
                  5'd14: m_ix = m_ix + fld;
                  default: ;
               endcase
               if (op == 5'd31) m_halt = 1'b1;
               else if (op == 5'd7) m_pc = fld;
               else if (op == 5'd8 && !m_ac[15]) m_pc = fld;
               else if (op == 5'd11 && m_ix == 10'd0) m_pc = fld;
               else begin
                  if (op == 5'd11) m_ix = m_ix + 10'd1;
                  m_pc = m_pc + 10'd1;
               end
            end
         endcase
      end
   end

   // lockstep comparison against the model, away from the active edge (R12)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic exp_we;
         logic [4:0] cop;
         cop = mref[m_pc][15:11];
         exp_we = !m_halt && ((phase == 3) || (phase == 2 && (cop == 5'd2 || cop == 5'd13)));
         checks++;
         if (dbg_ac !== m_ac || dbg_ix !== m_ix || dbg_pc !== m_pc ||
             halted !== m_halt || mem_we !== exp_we ||
             (phase == 0 && !m_halt && mem_addr !== m_pc)) begin
            failures++;
            $display("FAIL R12 lockstep actual=%h/%h/%h/%b/%b expected=%h/%h/%h/%b/%b",
                     dbg_ac, dbg_ix, dbg_pc, halted, mem_we,
                     m_ac, m_ix, m_pc, m_halt, exp_we);
         end
      end
   end

   task automatic put(int a, logic [15:0] d);
      ld_a  = a[9:0];
      ld_d  = d;
      ld_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic begin_load();
      @(negedge clk);
      rst_n  = 1'b0;
      clr_en = 1'b1;
      @(negedge clk);
      clr_en = 1'b0;
   endtask

   task automatic end_load();
      ld_en = 1'b0;
      @(negedge clk);
      chk("R1 pc in reset", dbg_pc, 0);
      chk("R1 ac in reset", dbg_ac, 0);
      chk("R1 halted/we in reset", {halted, mem_we}, 0);
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(int limit, output int cyc);
      cyc = 0;
      while (!halted && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
      if (!halted) begin
         checks++;
         failures++;
         $display("FAIL R10 watchdog actual=%0d expected=halt", cyc);
      end
   endtask

   initial begin
      int cyc;
      // program A: arithmetic, shifts, branches, undefined opcodes
      begin_load();
      put(0,  enc(1, 100, 0));
      put(1,  enc(3, 101, 0));
      put(2,  enc(4, 102, 0));
      put(3,  enc(2, 105, 0));
      put(4,  enc(6, 0, 0));
      put(5,  enc(2, 106, 0));
      put(6,  enc(5, 0, 0));
      put(7,  enc(5, 0, 0));
      put(8,  enc(2, 107, 0));
      put(9,  enc(8, 20, 0));
      put(10, enc(20, 108, 0));
      put(11, enc(15, 108, 0));
      put(12, enc(7, 16, 0));
      put(13, enc(31, 0, 0));
      put(16, enc(1, 100, 0));
      put(17, enc(8, 19, 0));
      put(18, enc(2, 104, 0));
      put(19, enc(31, 0, 0));
      put(20, enc(31, 0, 0));
      put(100, 16'd5);
      put(101, 16'd7);
      put(102, 16'd20);
      end_load();
      chk("R1 ix after reset release", dbg_ix, 0);
      run_to_halt(500, cyc);
      chk("R12 cycles program A", cyc, 48);
      chk("R2 load-add-sub-store", ram[105], 16'hFFF8);
      chk("R3 arithmetic shift right", ram[106], 16'hFFFC);
      chk("R3 two left shifts", ram[107], 16'hFFF0);
      chk("R4 final pc", dbg_pc, 19);
      chk("R4 taken jge skipped store", ram[104], 0);
      chk("R2 final ac", dbg_ac, 5);
      chk("R11 undefined opcodes no write", ram[108], 0);
      chk("R11 undefined opcodes ix", dbg_ix, 0);
      // mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 ac cleared by reset", dbg_ac, 0);
      chk("R1 pc/halt cleared by reset", {halted, dbg_pc}, 0);

      // program B: indexed loop, JZI, index load/store/increment
      begin_load();
      put(0,  enc(12, 50, 0));
      put(1,  enc(11, 7, 0));
      put(2,  enc(1, 203, 1));
      put(3,  enc(3, 213, 1));
      put(4,  enc(2, 223, 1));
      put(5,  enc(7, 1, 0));
      put(7,  enc(13, 51, 0));
      put(8,  enc(14, 10'h3FE, 0));
      put(9,  enc(13, 52, 0));
      put(10, enc(14, 5, 0));
      put(11, enc(13, 55, 0));
      put(12, enc(12, 53, 0));
      put(13, enc(13, 54, 0));
      put(14, enc(31, 0, 0));
      put(50, 16'hFFFC);
      put(53, 16'hABCD);
      for (int i = 0; i < 4; i++) begin
         put(200 + i, 16'(i + 1));
         put(210 + i, 16'(10 * (i + 1)));
      end
      end_load();
      run_to_halt(1000, cyc);
      chk("R12 cycles program B", cyc, 90);
      for (int i = 0; i < 4; i++)
         chk("R6 indexed vector sum", ram[220 + i], 16'(11 * (i + 1)));
      chk("R6 last ac", dbg_ac, 16'd44);
      chk("R7 jzi exits at zero", ram[51], 0);
      chk("R9 negative increment wraps", ram[52], 16'hFFFE);
      chk("R9 positive increment", ram[55], 16'h0003);
      chk("R8 ldix truncates", dbg_ix, 10'h3CD);
      chk("R8 stix sign-extends", ram[54], 16'hFFCD);

      // program C: address-field rewrite, halt behaviour
      begin_load();
      put(0, enc(9, 60, 0));
      put(1, enc(3, 61, 0));
      put(2, enc(10, 60, 0));
      put(3, enc(10, 62, 0));
      put(4, enc(9, 63, 0));
      put(5, enc(31, 0, 0));
      put(6, enc(2, 70, 0));
      put(60, enc(1, 300, 0));
      put(61, 16'd1);
      put(62, enc(2, 0, 1));
      put(63, 16'hFFFF);
      end_load();
      run_to_halt(500, cyc);
      chk("R12 cycles program C", cyc, 20);
      chk("R5 stadr rewrites field", ram[60], 16'h092D);
      chk("R5 stadr keeps index flag", ram[62], 16'h152D);
      chk("R5 ldadr zero-extends", dbg_ac, 16'h03FF);
      repeat (20) @(negedge clk);
      chk("R10 halted stays", halted, 1);
      chk("R10 pc frozen on halt", dbg_pc, 5);
      chk("R10 no fetch past halt", ram[70], 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL R10 global watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule